// File: doc/BRIEF.md
# Dual-Lane FP64 to INT32 Converter

This block takes a 128-bit word that holds two IEEE-754 double-precision numbers and turns each one into a signed 32-bit integer. The two integers fill the low 64 bits of a 128-bit result. The upper 64 bits of the result are always zero. A 2-bit mode input selects how inexact values are rounded. The block reports two sticky-free exception indications, invalid and inexact, which are each the OR over both lanes.

A mask input decides what happens to invalid lanes. With the mask set, any lane that cannot be represented returns the integer indefinite pattern `0x80000000`. With the mask clear, the block does not write a result. It raises a fault output so that a surrounding unit can take the trap, and the previous result stays on the output. The block has a single register stage: a request accepted on `in_valid` produces its result, flags and fault on the next cycle, qualified by `out_valid`.

Top module: `fp64i32_conv`

## Requirements
- R1: Result bits [31:0] are the conversion of input bits [63:0], and result bits [63:32] are the conversion of input bits [127:64].
- R2: Result bits [127:64] are zero at all times.
- R3: The mode input selects the rounding of inexact values: 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 truncates toward zero.
- R4: A lane whose rounded value falls outside [-2^31, 2^31-1] raises the invalid flag. A value that rounds to exactly -2^31 is valid and raises no invalid flag.
- R5: When `inv_mask` is 1, every invalid lane returns 0x80000000 and the other lane is converted normally.
- R6: A NaN or infinity (exponent field all ones) raises invalid and returns 0x80000000 when masked. That lane adds nothing to the inexact flag.
- R7: The inexact flag is 1 when any valid lane's rounded result differs from its input value, and 0 when both valid lanes are exact.
- R8: Zeros of either sign and denormals (exponent field zero) produce 0 in every rounding mode. A denormal raises inexact and a zero does not.
- R9: When `inv_mask` is 0 and a lane is invalid, the invalid flag and `out_fault` are 1 and `out_data` keeps its previous value.
- R10: `out_valid`, the flags and `out_fault` appear one cycle after `in_valid`. In a cycle where `out_valid` is 0, the flags and fault are 0 and `out_data` is held.
- R11: While reset is asserted, `out_valid`, both flags, `out_fault` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are taken on this cycle |
| in_data | input | 128 | Two FP64 operands; lane 0 in [63:0], lane 1 in [127:64] |
| rnd_mode | input | 2 | Rounding mode, encoded as in R3 |
| inv_mask | input | 1 | 1 = return indefinite on invalid, 0 = fault and hold |
| out_valid | output | 1 | Result, flags and fault are meaningful |
| out_data | output | 128 | Two INT32 results in [63:0], zero above |
| flag_invalid | output | 1 | Some lane was NaN, infinite or out of range |
| flag_inexact | output | 1 | Some valid lane was rounded |
| out_fault | output | 1 | Invalid occurred with the exception unmasked; no write |

## Verification
The checker assumes that `in_valid` comes from a source that is itself reset, so that the one-cycle relation between request and response holds from the first cycle after reset. It also assumes that `inv_mask` is sampled together with the operands in the same cycle. The bench drives all inputs on the falling edge and changes mask and mode only together with a new request, which keeps within both assumptions. The operand sweep stays within finite doubles, chosen quarter-steps, boundary values and explicit special encodings, so the real-number reference model in the bench never has to represent a value outside its exact integer range.

// File: rtl/fp64i32_pkg.sv
package fp64i32_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int BIAS   = 1023;
    localparam int INT_W  = 32;
    localparam int SHW    = $clog2(FP_W);

    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_TINY,
        CLS_NORM,
        CLS_SPECIAL
    } fpcls_e;

    typedef struct packed {
        logic           neg;
        fpcls_e         cls;
        logic           huge;
        logic [INT_W:0] mag;
        logic           guard;
        logic           sticky;
    } aligned_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } lane_res_t;

    // Decide whether the truncated magnitude must be bumped by one.
    function automatic logic rnd_inc(rmode_e mode, logic neg, logic lsb,
                                     logic guard, logic sticky);
        logic lost;
        lost = guard | sticky;
        case (mode)
            RM_NEAREST: rnd_inc = guard & (sticky | lsb);
            RM_DOWN:    rnd_inc = neg & lost;
            RM_UP:      rnd_inc = ~neg & lost;
            default:    rnd_inc = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fp64i32_align.sv
module fp64i32_align
    import fp64i32_pkg::*;
(
    input  logic [FP_W-1:0] fp_i,
    output aligned_t        al_o
);

    localparam int LOW_UE  = -2;
    localparam int HIGH_UE = INT_W - 1;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;
    logic [FP_W-1:0]  sig;
    logic [FP_W-1:0]  ipart;
    logic [FP_W-1:0]  lowmask;
    logic [SHW-1:0]   sh;
    logic [SHW-1:0]   sh1;
    int               ue;
    int               uec;

    always_comb begin
        expo = fp_i[FP_W-2 -: EXP_W];
        frac = fp_i[MAN_W-1:0];
        sig  = {{(FP_W-MAN_W-1){1'b0}}, 1'b1, frac};

        ue = int'(expo) - BIAS;
        if (ue < LOW_UE)
            uec = LOW_UE;
        else if (ue > HIGH_UE)
            uec = HIGH_UE;
        else
            uec = ue;

        sh      = SHW'(MAN_W - uec);
        sh1     = sh - SHW'(1);
        ipart   = sig >> sh;
        lowmask = (FP_W'(1) << sh1) - FP_W'(1);

        al_o.neg    = fp_i[FP_W-1];
        al_o.huge   = (ue >= INT_W);
        al_o.mag    = ipart[INT_W:0];
        al_o.guard  = sig[sh1];
        al_o.sticky = |(sig & lowmask);

        if (&expo)
            al_o.cls = CLS_SPECIAL;
        else if (expo == '0)
            al_o.cls = (frac == '0) ? CLS_ZERO : CLS_TINY;
        else
            al_o.cls = CLS_NORM;
    end

endmodule

// File: rtl/fp64i32_round.sv
module fp64i32_round
    import fp64i32_pkg::*;
(
    input  aligned_t  al_i,
    input  rmode_e    mode_i,
    output lane_res_t res_o
);

    localparam logic [INT_W:0] POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
    localparam logic [INT_W:0] NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

    logic           inc;
    logic [INT_W:0] mag_r;
    logic           over;
    logic [INT_W-1:0] mag_lo;

    always_comb begin
        inc    = rnd_inc(mode_i, al_i.neg, al_i.mag[0], al_i.guard, al_i.sticky);
        mag_r  = al_i.mag + {{INT_W{1'b0}}, inc};
        over   = al_i.neg ? (mag_r > NEG_LIM) : (mag_r > POS_LIM);
        mag_lo = mag_r[INT_W-1:0];

        res_o.value   = '0;
        res_o.invalid = 1'b0;
        res_o.inexact = 1'b0;

        case (al_i.cls)
            CLS_SPECIAL: begin
                res_o.value   = INDEF;
                res_o.invalid = 1'b1;
            end
            CLS_ZERO: ;
            CLS_TINY: res_o.inexact = 1'b1;
            default: begin
                if (al_i.huge || over) begin
                    res_o.value   = INDEF;
                    res_o.invalid = 1'b1;
                end else begin
                    res_o.value   = al_i.neg ? (~mag_lo + 1'b1) : mag_lo;
                    res_o.inexact = al_i.guard | al_i.sticky;
                end
            end
        endcase
    end

endmodule

// File: rtl/fp64i32_pack.sv
module fp64i32_pack
    import fp64i32_pkg::*;
#(
    parameter int LANES = 2
) (
    input  lane_res_t [LANES-1:0]   res_i,
    output logic [LANES*FP_W-1:0]   data_o,
    output logic                    any_inv_o,
    output logic                    any_inx_o
);

    localparam int LOW_W = LANES * INT_W;
    localparam int TOT_W = LANES * FP_W;

    logic [LANES-1:0] inv_v;
    logic [LANES-1:0] inx_v;

    for (genvar l = 0; l < LANES; l++) begin : g_slot
        assign data_o[l*INT_W +: INT_W] = res_i[l].value;
        assign inv_v[l] = res_i[l].invalid;
        assign inx_v[l] = res_i[l].inexact;
    end

    assign data_o[TOT_W-1:LOW_W] = '0;
    assign any_inv_o = |inv_v;
    assign any_inx_o = |inx_v;

endmodule

// File: rtl/fp64i32_conv.sv
module fp64i32_conv
    import fp64i32_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*FP_W-1:0] in_data,
    input  logic [1:0]            rnd_mode,
    input  logic                  inv_mask,
    output logic                  out_valid,
    output logic [LANES*FP_W-1:0] out_data,
    output logic                  flag_invalid,
    output logic                  flag_inexact,
    output logic                  out_fault
);

    localparam int DATA_W = LANES * FP_W;

    rmode_e               mode;
    lane_res_t [LANES-1:0] lane_res;
    logic [DATA_W-1:0]    packed_res;
    logic                 any_inv;
    logic                 any_inx;
    logic                 trap;

    assign mode = rmode_e'(rnd_mode);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aligned_t al;

        fp64i32_align u_align (
            .fp_i (in_data[l*FP_W +: FP_W]),
            .al_o (al)
        );

        fp64i32_round u_round (
            .al_i   (al),
            .mode_i (mode),
            .res_o  (lane_res[l])
        );
    end

    fp64i32_pack #(.LANES(LANES)) u_pack (
        .res_i     (lane_res),
        .data_o    (packed_res),
        .any_inv_o (any_inv),
        .any_inx_o (any_inx)
    );

    assign trap = any_inv & ~inv_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            out_fault    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                flag_invalid <= any_inv;
                flag_inexact <= any_inx;
                out_fault    <= trap;
                if (!trap)
                    out_data <= packed_res;
            end else begin
                flag_invalid <= 1'b0;
                flag_inexact <= 1'b0;
                out_fault    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fp64i32_chk.sv
module fp64i32_chk
    import fp64i32_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  inv_mask,
    input logic                  out_valid,
    input logic [LANES*FP_W-1:0] out_data,
    input logic                  flag_invalid,
    input logic                  flag_inexact,
    input logic                  out_fault
);

    localparam int LOW_W = LANES * INT_W;
    localparam int TOT_W = LANES * FP_W;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        out_valid == $past(in_valid));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_data[TOT_W-1:LOW_W] == '0);

    // R9
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        out_fault |-> (flag_invalid && !$past(inv_mask)));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        out_fault |-> (out_data == $past(out_data)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !out_valid |-> (!flag_invalid && !flag_inexact && !out_fault && $stable(out_data)));

    // R5
    indef_present_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid && !out_fault) |->
            (out_data[INT_W-1:0] == INDEF || out_data[2*INT_W-1:INT_W] == INDEF));

endmodule

bind fp64i32_conv fp64i32_chk #(.LANES(LANES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .inv_mask     (inv_mask),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .out_fault    (out_fault)
);

// File: tb/fp64i32_conv_tb.sv
module fp64i32_conv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVAL_MAX   = 80;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         inv_mask = 1'b1;
    logic         out_valid;
    logic [127:0] out_data;
    logic         flag_invalid;
    logic         flag_inexact;
    logic         out_fault;

    int checks = 0;
    int failures = 0;
    logic [127:0] exp_hold = '0;

    logic [63:0] vals [0:NVAL_MAX-1];
    int nval = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp64i32_conv dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .rnd_mode     (rnd_mode),
        .inv_mask     (inv_mask),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact),
        .out_fault    (out_fault)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Reference conversion of one lane, built from the requirement text.
    task automatic ref_lane(input logic [63:0] bits, input logic [1:0] mode,
                            output logic [31:0] v, output bit inv, output bit inx);
        real x, f, r, d;
        v = 32'h0; inv = 0; inx = 0;
        if (bits[62:52] == 11'h7FF) begin
            inv = 1;
        end else if (bits[62:52] == 11'h000) begin
            inx = (bits[51:0] != 0);
        end else begin
            x = $bitstoreal(bits);
            if (x >= 8589934592.0 || x <= -8589934592.0) begin
                inv = 1;
            end else begin
                case (mode)
                    2'b01: r = $floor(x);
                    2'b10: r = $ceil(x);
                    2'b11: r = (x < 0.0) ? $ceil(x) : $floor(x);
                    default: begin
                        f = $floor(x);
                        d = x - f;
                        if (d > 0.5) r = f + 1.0;
                        else if (d < 0.5) r = f;
                        else r = ((longint'(f) % 2) != 0) ? f + 1.0 : f;
                    end
                endcase
                if (r > 2147483647.0 || r < -2147483648.0) inv = 1;
                else begin
                    v = 32'(longint'(r));
                    inx = (r != x);
                end
            end
        end
        if (inv) begin
            v = 32'h8000_0000;
            inx = 0;
        end
    endtask

    // Present one request at the falling edge and check the response one cycle later.
    task automatic apply(input logic [63:0] lo, input logic [63:0] hi,
                         input logic [1:0] mode, input logic mask, input string tag);
        logic [31:0] v0, v1;
        bit i0, i1, x0, x1, einv, einx, efault;
        logic [127:0] edata;
        ref_lane(lo, mode, v0, i0, x0);
        ref_lane(hi, mode, v1, i1, x1);
        einv   = i0 | i1;
        einx   = x0 | x1;
        efault = einv & ~mask;
        edata  = efault ? exp_hold : {64'h0, v1, v0};
        in_valid = 1'b1;
        in_data  = {hi, lo};
        rnd_mode = mode;
        inv_mask = mask;
        @(negedge clk);
        chk(out_valid === 1'b1, tag, "out_valid", {127'h0, out_valid}, 128'h1);
        chk(out_data[31:0] === edata[31:0], tag, "lane0", {96'h0, out_data[31:0]}, {96'h0, edata[31:0]});
        chk(out_data[63:32] === edata[63:32], tag, "lane1", {96'h0, out_data[63:32]}, {96'h0, edata[63:32]});
        chk(out_data[127:64] === 64'h0, tag, "upper", {64'h0, out_data[127:64]}, 128'h0);
        chk(flag_invalid === einv, tag, "invalid", {127'h0, flag_invalid}, {127'h0, einv});
        chk(flag_inexact === einx, tag, "inexact", {127'h0, flag_inexact}, {127'h0, einx});
        chk(out_fault === efault, tag, "fault", {127'h0, out_fault}, {127'h0, efault});
        exp_hold = edata;
    endtask

    task automatic idle_cycle(input string tag);
        in_valid = 1'b0;
        in_data  = {64'h7FF0_0000_0000_0000, 64'h4004_0000_0000_0000};
        @(negedge clk);
        chk(out_valid === 1'b0, tag, "idle out_valid", {127'h0, out_valid}, 128'h0);
        chk(flag_invalid === 1'b0 && flag_inexact === 1'b0 && out_fault === 1'b0,
            tag, "idle flags", {125'h0, flag_invalid, flag_inexact, out_fault}, 128'h0);
        chk(out_data === exp_hold, tag, "idle hold", out_data, exp_hold);
    endtask

    function automatic logic [63:0] d(input real r);
        return $realtobits(r);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R11", "reset out_valid", {127'h0, out_valid}, 128'h0);
        chk(out_data === 128'h0, "R11", "reset out_data", out_data, 128'h0);
        chk(flag_invalid === 1'b0 && flag_inexact === 1'b0 && out_fault === 1'b0,
            "R11", "reset flags", {125'h0, flag_invalid, flag_inexact, out_fault}, 128'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: lane placement with distinct values
        apply(d(3.0), d(-7.0), 2'b11, 1'b1, "R1");
        apply(d(-100000.0), d(65536.0), 2'b00, 1'b1, "R1");

        // R3: each mode on ties and fractions
        for (int m = 0; m < 4; m++) begin
            apply(d(2.5), d(-2.5), 2'(m), 1'b1, "R3");
            apply(d(3.5), d(-0.75), 2'(m), 1'b1, "R3");
        end

        // R4: range edges
        apply(d(2147483647.0), d(-2147483648.0), 2'b00, 1'b1, "R4");
        apply(d(2147483648.0), d(1.0), 2'b00, 1'b1, "R4");
        apply(d(2147483647.5), d(-2147483648.5), 2'b11, 1'b1, "R4");
        apply(d(2147483647.5), d(-2147483648.5), 2'b00, 1'b1, "R4");
        apply(d(-2147483648.25), d(2147483647.25), 2'b01, 1'b1, "R4");

        // R5: masked invalid in one lane only
        apply(d(1.0e20), d(42.0), 2'b00, 1'b1, "R5");
        apply(d(-9.0), d(-5.0e9), 2'b10, 1'b1, "R5");

        // R6: NaN and infinities; other lane decides inexact
        apply(64'h7FF8_0000_0000_0000, d(2.0), 2'b11, 1'b1, "R6");
        apply(64'hFFF0_0000_0000_0000, d(2.25), 2'b11, 1'b1, "R6");
        apply(d(6.0), 64'h7FF0_0000_0000_0000, 2'b00, 1'b1, "R6");

        // R7: inexact OR across lanes
        apply(d(8.0), d(-8.0), 2'b00, 1'b1, "R7");
        apply(d(8.0), d(-8.125), 2'b00, 1'b1, "R7");

        // R8: zeros and denormals in every mode
        for (int m = 0; m < 4; m++) begin
            apply(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 2'(m), 1'b1, "R8");
            apply(64'h0000_0000_0000_0000, 64'h800F_FFFF_FFFF_FFFF, 2'(m), 1'b1, "R8");
        end

        // R9: unmasked invalid holds the previous result
        apply(d(11.0), d(-12.0), 2'b00, 1'b1, "R9");
        apply(d(5.0e10), d(3.0), 2'b00, 1'b0, "R9");
        apply(64'h7FF8_0000_0000_0001, d(3.0), 2'b00, 1'b0, "R9");
        apply(d(4.0), d(5.0), 2'b00, 1'b0, "R9");

        // R10: gap cycle
        idle_cycle("R10");
        apply(d(-1.5), d(1.5), 2'b00, 1'b1, "R10");
        idle_cycle("R10");

        // R3 sweep: quarter steps plus boundary and special values
        for (int k = -24; k <= 24; k++) begin
            vals[nval] = d(real'(k) / 4.0);
            nval++;
        end
        vals[nval++] = 64'h7FF0_0000_0000_0000;
        vals[nval++] = 64'hFFF0_0000_0000_0000;
        vals[nval++] = 64'h7FF8_0000_0000_0000;
        vals[nval++] = 64'h0000_0000_0000_0001;
        vals[nval++] = 64'h8000_0000_0000_0001;
        vals[nval++] = 64'h8000_0000_0000_0000;
        vals[nval++] = d(2147483647.0);
        vals[nval++] = d(2147483647.5);
        vals[nval++] = d(2147483647.25);
        vals[nval++] = d(2147483648.0);
        vals[nval++] = d(-2147483648.0);
        vals[nval++] = d(-2147483648.5);
        vals[nval++] = d(-2147483648.75);
        vals[nval++] = d(-2147483649.0);
        vals[nval++] = d(1.0e300);
        vals[nval++] = d(1.0e-300);
        vals[nval++] = d(4294967295.5);
        vals[nval++] = d(3.0e9);
        vals[nval++] = d(-1234567.375);
        vals[nval++] = d(0.4999999999);

        for (int m = 0; m < 4; m++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int i = 0; i < nval; i++) begin
                    apply(vals[i], vals[(i * 13 + 5) % nval], 2'(m), 1'(mk), "R3");
                end
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule